// File: doc/BRIEF.md
# Flash Page-Program Write Buffer

This block stages one 128-byte chunk for programming a serial NOR flash and then shifts it out over a single-data-line SPI link. Software first switches a shared buffer from its read-prefetch role into its program role with a mode bit. Because the switch takes several cycles to take effect, software reads the bit back until it shows the new value. Software then loads a 32-bit target address through four byte-wide address registers and pushes 32 words into a fill port. A program command follows. The block then sends the program opcode, the four address bytes (most significant first) and all 128 buffered bytes in one chip-select frame.

A second command sends a one-byte programmed write: the single-write opcode, the same four address bytes and one data byte taken from a dedicated register. Software uses this path for the tail of a transfer that does not fill a chunk. Register accesses use a simple single-cycle write strobe with a combinational read-back. Every register write is ignored while a frame is in flight.

The sequencer has five states. SQ_IDLE leaves for SQ_OPCODE when a program or single command is accepted. SQ_OPCODE moves to SQ_ADDR after the opcode byte. SQ_ADDR moves to SQ_DATA after the fourth address byte. SQ_DATA moves to SQ_CLOSE after the last data byte: the 128th for a program, the first for a single write. SQ_CLOSE returns to SQ_IDLE after one cycle, and the command's low bits clear in that same cycle.

Top module: `flash_pp_wbuf`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0, prog_err is 0, the command register (offset 0x00) reads 0 and the mode register (offset 0x64) reads 0.
- R2: The buffer role is bit 0 of the mode register at offset 0x64: 0 means prefetch and 1 means program. After a write, the value read back keeps its old state for at least one cycle. It shows the new value within MODE_LAT+2 cycles.
- R3: The fill port (offset 0x98) takes 32-bit words in little-endian order: bits 7:0 are the lowest-addressed byte. Data bytes go out in ascending address order, starting with byte 0 of word 0.
- R4: A program frame begins with opcode PAGE_OPC (default 0x12). It is followed by the address bytes from offsets 0xC8, 0x18, 0x14 and 0x10, in that order. Each byte is sent MSB first, with data valid on the rising edge of spi_sclk while spi_cs_n is 0.
- R5: A program frame carries exactly 128 data bytes, for a total of 133 bytes, after which spi_cs_n returns to 1.
- R6: Writing 0x10 to the command register while the mode bit reads 1 starts a program. The command register reads 0x10 while the frame is in flight, and its low five bits read 0 once the frame is complete.
- R7: Writing 0x90 to the command register sends SINGLE_OPC (default 0x02), the four address bytes and the byte held at offset 0x1C, six bytes in total. Afterwards the command register reads 0x80.
- R8: The word pointer advances on each fill-port write and wraps to word 0 after the 32nd word, so a 33rd word overwrites word 0.
- R9: Starting a program resets the word pointer to word 0.
- R10: Writing 0x10 while the mode bit reads 0 sets prog_err, sends no frame and leaves the command register unchanged. prog_err clears when a command is next accepted.
- R11: While a frame is in flight, writes to the address registers and to the fill port have no effect. The address registers read back unchanged, and neither the buffer contents nor the word pointer are affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read-back of the register at bus_addr |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data out |
| prog_err | output | 1 | Set when a program command is refused in prefetch role |

## Verification
Two functions can fall in the same cycle: a register write arriving from software, and an active frame. While the sequencer is draining the buffer and the address bytes onto the link, a fill-port or address write could corrupt data that is still being sent. The bench provokes this by writing a new address byte and a new fill word while a program frame is being shifted. It judges the result at the ports: it reads the address register back, and it compares the data bytes of the next program frame, which must still start with the earlier word at word 0.

// File: rtl/flash_wbuf_pkg.sv
`timescale 1ns/1ps
package flash_wbuf_pkg;

    // register offsets seen by software
    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_A0    = 8'h10;
    localparam logic [7:0] OFS_A1    = 8'h14;
    localparam logic [7:0] OFS_A2    = 8'h18;
    localparam logic [7:0] OFS_SBYTE = 8'h1C;
    localparam logic [7:0] OFS_MODE  = 8'h64;
    localparam logic [7:0] OFS_FILL  = 8'h98;
    localparam logic [7:0] OFS_A3    = 8'hC8;

    // command codes
    localparam logic [7:0] CMD_PAGE   = 8'h10;
    localparam logic [7:0] CMD_SINGLE = 8'h90;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_OPCODE,
        SQ_ADDR,
        SQ_DATA,
        SQ_CLOSE
    } seq_state_t;

endpackage

// File: rtl/wbuf_regs.sv
`timescale 1ns/1ps
module wbuf_regs
    import flash_wbuf_pkg::*;
#(
    parameter int MODE_LAT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic            busy,
    input  logic            done,
    output logic            mode_eff,
    output logic            fill_we,
    output logic [3:0][7:0] addr_bytes,
    output logic [7:0]      single_byte,
    output logic            start_page,
    output logic            start_single,
    output logic            prog_err,
    output logic [7:0]      cmd_q
);

    logic              wr_ok;
    logic              cmd_wr;
    logic              page_refused;
    logic              mode_req;
    logic [MODE_LAT-1:0] mode_pipe;

    always_comb begin
        wr_ok        = bus_wr && !busy;
        cmd_wr       = wr_ok && (bus_addr == OFS_CMD);
        start_page   = cmd_wr && (bus_wdata[7:0] == CMD_PAGE) && mode_eff;
        page_refused = cmd_wr && (bus_wdata[7:0] == CMD_PAGE) && !mode_eff;
        start_single = cmd_wr && (bus_wdata[7:0] == CMD_SINGLE);
        fill_we      = wr_ok && (bus_addr == OFS_FILL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q       <= 8'h00;
            prog_err    <= 1'b0;
            addr_bytes  <= '0;
            single_byte <= 8'h00;
            mode_req    <= 1'b0;
        end else begin
            if (start_page || start_single) begin
                cmd_q    <= bus_wdata[7:0];
                prog_err <= 1'b0;
            end else if (done) begin
                cmd_q[4:0] <= 5'd0;
            end
            if (page_refused)
                prog_err <= 1'b1;
            if (wr_ok) begin
                unique case (bus_addr)
                    OFS_A0:    addr_bytes[0] <= bus_wdata[7:0];
                    OFS_A1:    addr_bytes[1] <= bus_wdata[7:0];
                    OFS_A2:    addr_bytes[2] <= bus_wdata[7:0];
                    OFS_A3:    addr_bytes[3] <= bus_wdata[7:0];
                    OFS_SBYTE: single_byte   <= bus_wdata[7:0];
                    OFS_MODE:  mode_req      <= bus_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    // role switch settles after MODE_LAT cycles
    generate
        if (MODE_LAT == 1) begin : g_lat1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mode_pipe <= '0;
                else        mode_pipe <= mode_req;
            end
        end else begin : g_latn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mode_pipe <= '0;
                else        mode_pipe <= {mode_pipe[MODE_LAT-2:0], mode_req};
            end
        end
    endgenerate

    assign mode_eff = mode_pipe[MODE_LAT-1];

    always_comb begin
        unique case (bus_addr)
            OFS_CMD:   bus_rdata = {24'd0, cmd_q};
            OFS_A0:    bus_rdata = {24'd0, addr_bytes[0]};
            OFS_A1:    bus_rdata = {24'd0, addr_bytes[1]};
            OFS_A2:    bus_rdata = {24'd0, addr_bytes[2]};
            OFS_A3:    bus_rdata = {24'd0, addr_bytes[3]};
            OFS_SBYTE: bus_rdata = {24'd0, single_byte};
            OFS_MODE:  bus_rdata = {31'd0, mode_eff};
            default:   bus_rdata = 32'd0;
        endcase
    end

    // R10
    refuse_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_refused |=> (prog_err && cmd_q == $past(cmd_q)));

    // R11
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_bytes));

endmodule

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
module wbuf_store #(
    parameter int BYTES = 128,
    localparam int WORDS = BYTES / 4,
    localparam int PW = $clog2(WORDS),
    localparam int IW = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [31:0]   wdata,
    input  logic          restart,
    input  logic          busy,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [31:0]   mem [WORDS];
    logic [PW-1:0] ptr;
    logic [31:0]   word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (restart) begin
            ptr <= '0;
        end else if (we) begin
            ptr <= (ptr == PW'(WORDS - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !restart)
            mem[ptr] <= wdata;
    end

    always_comb begin
        word    = mem[rd_idx[IW-1:2]];
        rd_byte = 8'(word >> {rd_idx[1:0], 3'b000});
    end

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !restart && ptr == PW'(WORDS - 1)) |=> (ptr == '0));

    // R11
    busy_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr));

endmodule

// File: rtl/wbuf_shifter.sv
`timescale 1ns/1ps
module wbuf_shifter #(
    parameter int HALF = 1,
    localparam int HCW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done
);

    logic           active;
    logic           phase;
    logic [2:0]     bitcnt;
    logic [HCW-1:0] hcnt;
    logic [7:0]     sh;
    logic           half_end;

    always_comb begin
        half_end  = (hcnt == HCW'(HALF - 1));
        byte_done = active && phase && half_end && (bitcnt == 3'd7);
        sclk      = active && phase;
        mosi      = active && sh[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            phase  <= 1'b0;
            bitcnt <= 3'd0;
            hcnt   <= '0;
            sh     <= 8'h00;
        end else if (load) begin
            active <= 1'b1;
            phase  <= 1'b0;
            bitcnt <= 3'd0;
            hcnt   <= '0;
            sh     <= din;
        end else if (active) begin
            if (half_end) begin
                hcnt <= '0;
                if (!phase) begin
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (bitcnt == 3'd7) begin
                        active <= 1'b0;
                    end else begin
                        bitcnt <= bitcnt + 3'd1;
                        sh     <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

    // R4
    load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!active || byte_done));

endmodule

// File: rtl/flash_pp_wbuf.sv
`timescale 1ns/1ps
module flash_pp_wbuf
    import flash_wbuf_pkg::*;
#(
    parameter int         BYTES      = 128,
    parameter int         MODE_LAT   = 4,
    parameter int         HALF       = 1,
    parameter logic [7:0] PAGE_OPC   = 8'h12,
    parameter logic [7:0] SINGLE_OPC = 8'h02,
    localparam int        IW         = $clog2(BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    output logic        prog_err
);

    seq_state_t      state, nstate;
    logic [IW-1:0]   idx, nidx;
    logic            is_page, nis_page;
    logic            busy, done;
    logic            load;
    logic [7:0]      tx_byte;
    logic [IW-1:0]   store_idx;
    logic [7:0]      store_byte;
    logic            byte_done;
    logic            mode_eff;
    logic            fill_we;
    logic [3:0][7:0] addr_bytes;
    logic [7:0]      single_byte;
    logic            start_page, start_single;
    logic [7:0]      cmd_q;

    wbuf_regs #(.MODE_LAT(MODE_LAT)) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .busy         (busy),
        .done         (done),
        .mode_eff     (mode_eff),
        .fill_we      (fill_we),
        .addr_bytes   (addr_bytes),
        .single_byte  (single_byte),
        .start_page   (start_page),
        .start_single (start_single),
        .prog_err     (prog_err),
        .cmd_q        (cmd_q)
    );

    wbuf_store #(.BYTES(BYTES)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (fill_we),
        .wdata   (bus_wdata),
        .restart (start_page),
        .busy    (busy),
        .rd_idx  (store_idx),
        .rd_byte (store_byte)
    );

    wbuf_shifter #(.HALF(HALF)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .din       (tx_byte),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_done (byte_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            is_page <= 1'b0;
        end else begin
            state   <= nstate;
            idx     <= nidx;
            is_page <= nis_page;
        end
    end

    // buffer read index: first data byte while addressing, else next byte
    always_comb begin
        store_idx = (state == SQ_ADDR) ? '0 : idx + 1'b1;
    end

    // transitions and byte issue
    always_comb begin
        nstate   = state;
        nidx     = idx;
        nis_page = is_page;
        load     = 1'b0;
        tx_byte  = 8'h00;
        done     = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (start_page || start_single) begin
                    nstate   = SQ_OPCODE;
                    nis_page = start_page;
                    nidx     = '0;
                    load     = 1'b1;
                    tx_byte  = start_page ? PAGE_OPC : SINGLE_OPC;
                end
            end
            SQ_OPCODE: begin
                if (byte_done) begin
                    nstate  = SQ_ADDR;
                    nidx    = '0;
                    load    = 1'b1;
                    tx_byte = addr_bytes[3];
                end
            end
            SQ_ADDR: begin
                if (byte_done) begin
                    load = 1'b1;
                    if (idx == IW'(3)) begin
                        nstate  = SQ_DATA;
                        nidx    = '0;
                        tx_byte = is_page ? store_byte : single_byte;
                    end else begin
                        nidx    = idx + 1'b1;
                        tx_byte = addr_bytes[2'd2 - idx[1:0]];
                    end
                end
            end
            SQ_DATA: begin
                if (byte_done) begin
                    if (!is_page || idx == IW'(BYTES - 1)) begin
                        nstate = SQ_CLOSE;
                    end else begin
                        nidx    = idx + 1'b1;
                        load    = 1'b1;
                        tx_byte = store_byte;
                    end
                end
            end
            SQ_CLOSE: begin
                done   = 1'b1;
                nstate = SQ_IDLE;
            end
            default: nstate = SQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state != SQ_IDLE);
        spi_cs_n = !((state == SQ_OPCODE) || (state == SQ_ADDR) || (state == SQ_DATA));
    end

    // R6
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_IDLE) == (cmd_q[4:0] != 5'd0));

    // R5
    page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_CLOSE && is_page) |-> ($past(idx) == IW'(BYTES - 1)));

endmodule

// File: tb/flash_pp_wbuf_tb.sv
`timescale 1ns/1ps
module flash_pp_wbuf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        spi_sclk, spi_cs_n, spi_mosi, prog_err;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    flash_pp_wbuf dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .prog_err  (prog_err)
    );

    always #5 clk = ~clk;

    // link monitor, sampled away from the active edge
    logic [7:0] cap [0:199];
    int         cap_n = 0;
    int         frames = 0;
    int         bc = 0;
    logic [7:0] sh = 8'h00;
    logic       prev_sclk = 1'b0;
    logic       prev_cs = 1'b1;

    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            frames = frames + 1;
            cap_n  = 0;
            bc     = 0;
        end
        if (!spi_cs_n && spi_sclk && !prev_sclk) begin
            sh = {sh[6:0], spi_mosi};
            bc = bc + 1;
            if (bc == 8) begin
                if (cap_n < 200) cap[cap_n] = sh;
                cap_n = cap_n + 1;
                bc = 0;
            end
        end
        prev_sclk = spi_sclk;
        prev_cs   = spi_cs_n;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 4000; i++) begin
            rd(8'h00, c);
            if (c[4:0] == 5'd0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic set_addr(input logic [31:0] a);
        wr(8'hC8, {24'd0, a[31:24]});
        wr(8'h18, {24'd0, a[23:16]});
        wr(8'h14, {24'd0, a[15:8]});
        wr(8'h10, {24'd0, a[7:0]});
    endtask

    task automatic set_mode(input bit m);
        logic [31:0] v;
        wr(8'h64, {31'd0, m});
        for (int i = 0; i < 20; i++) begin
            rd(8'h64, v);
            if (v[0] == m) break;
        end
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input logic [7:0] step, input int k);
        return 8'(seed + 8'(k) * step);
    endfunction

    // stimulus/expected table: target address, pattern seed, pattern step
    localparam logic [47:0] VEC [3] = '{
        {32'h0000_0000, 8'h00, 8'h01},
        {32'h01FF_FF80, 8'hA5, 8'h03},
        {32'hFEDC_BA00, 8'hFF, 8'hFF}
    };

    initial begin
        logic [31:0] v;
        logic [31:0] a;
        logic [7:0]  sd, st;
        int          bad;
        int          f0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R1 link idle", {spi_cs_n, spi_sclk}, 2'b10);
        check(prog_err === 1'b0, "R1 err", prog_err, 0);
        rd(8'h00, v); check(v === 32'd0, "R1 cmd", v, 0);
        rd(8'h64, v); check(v === 32'd0, "R1 mode", v, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h00, v); check(v === 32'd0, "R1 cmd after release", v, 0);

        // R2 role switch latency
        wr(8'h64, 32'd1);
        rd(8'h64, v); check(v[0] === 1'b0, "R2 old value held", v, 0);
        bad = 1;
        for (int i = 0; i < 6; i++) begin
            rd(8'h64, v);
            if (v[0] === 1'b1) begin bad = 0; break; end
        end
        check(bad == 0, "R2 new value visible", v, 1);

        // table walk: R3 R4 R5 R6
        for (int r = 0; r < 3; r++) begin
            a  = VEC[r][47:16];
            sd = VEC[r][15:8];
            st = VEC[r][7:0];
            set_addr(a);
            for (int w = 0; w < 32; w++)
                wr(8'h98, {pat(sd, st, 4*w+3), pat(sd, st, 4*w+2), pat(sd, st, 4*w+1), pat(sd, st, 4*w)});
            wr(8'h00, 32'h10);
            rd(8'h00, v); check(v === 32'h10, "R6 busy readback", v, 32'h10);
            wait_idle();
            rd(8'h00, v); check(v === 32'h00, "R6 low bits cleared", v, 0);
            check(cap_n == 133, "R5 frame length", cap_n, 133);
            check(cap[0] == 8'h12 && {cap[1], cap[2], cap[3], cap[4]} == a, "R4 opcode and address",
                  {cap[1], cap[2], cap[3], cap[4]}, a);
            bad = 0;
            for (int k = 0; k < 128; k++)
                if (cap[5+k] != pat(sd, st, k)) bad++;
            check(bad == 0, "R3 data byte order", bad, 0);
        end

        // R8 wrap: 33 words, last overwrites word 0
        set_addr(32'h0000_1000);
        for (int w = 0; w < 33; w++)
            wr(8'h98, 32'h1000_0000 + w);
        wr(8'h00, 32'h10);
        wait_idle();
        check({cap[8], cap[7], cap[6], cap[5]} == 32'h1000_0020, "R8 word0 overwritten",
              {cap[8], cap[7], cap[6], cap[5]}, 32'h1000_0020);
        check({cap[12], cap[11], cap[10], cap[9]} == 32'h1000_0001, "R8 word1 kept",
              {cap[12], cap[11], cap[10], cap[9]}, 32'h1000_0001);

        // R9 pointer reset at program start
        wr(8'h98, 32'hCAFE_F00D);
        wr(8'h00, 32'h10);
        // R11 writes during an active frame
        repeat (20) @(negedge clk);
        wr(8'h10, 32'hAB);
        wr(8'h98, 32'h1234_5678);
        wait_idle();
        check({cap[8], cap[7], cap[6], cap[5]} == 32'hCAFE_F00D, "R9 pointer restarted",
              {cap[8], cap[7], cap[6], cap[5]}, 32'hCAFE_F00D);
        rd(8'h10, v); check(v === 32'h00, "R11 address write ignored", v, 0);
        wr(8'h00, 32'h10);
        wait_idle();
        check({cap[8], cap[7], cap[6], cap[5]} == 32'hCAFE_F00D, "R11 fill write ignored",
              {cap[8], cap[7], cap[6], cap[5]}, 32'hCAFE_F00D);

        // R10 refused program in prefetch role
        set_mode(1'b0);
        f0 = frames;
        wr(8'h00, 32'h10);
        @(negedge clk);
        check(prog_err === 1'b1, "R10 err set", prog_err, 1);
        rd(8'h00, v); check(v === 32'h00, "R10 cmd unchanged", v, 0);
        repeat (300) @(negedge clk);
        check(frames == f0, "R10 no frame", frames - f0, 0);

        // R7 single byte write, also clears the error (R10)
        set_addr(32'h0A0B_0C0D);
        wr(8'h1C, 32'h5A);
        wr(8'h00, 32'h90);
        @(negedge clk);
        check(prog_err === 1'b0, "R10 err cleared", prog_err, 0);
        wait_idle();
        check(cap_n == 6 && cap[0] == 8'h02 && cap[5] == 8'h5A, "R7 single frame",
              {cap_n[7:0], cap[0], cap[5]}, {8'd6, 8'h02, 8'h5A});
        check({cap[1], cap[2], cap[3], cap[4]} == 32'h0A0B_0C0D, "R7 single address",
              {cap[1], cap[2], cap[3], cap[4]}, 32'h0A0B_0C0D);
        rd(8'h00, v); check(v === 32'h80, "R7 cmd after single", v, 32'h80);
        check(spi_cs_n === 1'b1, "R5 cs released", spi_cs_n, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule